// File: doc/BRIEF.md
# Dual Tri-State Phase-Frequency Detector

This block holds two phase-frequency detectors, one for a transmit synthesizer loop and one for a receive synthesizer loop. Both compare a single shared reference pulse train with the output of their own programmable divider. Each detector sets a "pump up" flag on a reference rising edge and a "pump down" flag on a divider rising edge, and clears both flags as soon as both have been seen. The flags drive a charge-pump style tri-state output toward an external loop filter. That output is modelled as a drive-enable and a drive-level pair: the level is high while only up is pending, low while only down is pending, and the output floats otherwise.

All inputs are sampled in the system-clock domain, and only rising edges count. An active-low standby input holds the transmit detector in reset with its output floating. The receive detector keeps running during standby. For lock monitoring, each detector reports the length in clock cycles of its most recent error pulse, saturating at the counter's ceiling, together with the polarity of that pulse.

Top module: `dual_pfd`

## Requirements
- R1: While reset is asserted, and right after it is released, both drive-enables are 0 and both error widths and lead flags are 0.
- R2: On an idle detector, a reference rising edge with no divider rising edge sampled on the same clock makes that detector's drive-enable 1 and drive-level 1 from the next clock edge.
- R3: On an idle detector, a divider rising edge with no reference rising edge sampled on the same clock gives drive-enable 1 and drive-level 0 from the next clock edge.
- R4: While one direction is pending, a rising edge of the opposite input clears it, and drive-enable returns to 0 after that clock edge.
- R5: A reference edge and a divider edge sampled on the same clock leave that detector floating, and its error width and lead flag keep their values.
- R6: A further rising edge on the same input while its direction is already pending does not change the output, and the pulse length keeps counting.
- R7: While standby_n is 0, the transmit detector is held cleared: its drive-enable, error width and lead flag are all 0. The receive detector is not affected.
- R8: Leaving standby while the reference or the transmit divider input is already high produces no output pulse. A later rising edge is handled normally.
- R9: One clock after an error pulse ends, err_width holds the number of clock cycles that drive-enable was 1, and err_lead holds 1 if the pulse drove high and 0 if it drove low.
- R10: The reported error width saturates at 2^CW-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference pulse train, shared by both detectors |
| tx_div_in | input | 1 | Transmit divider output |
| rx_div_in | input | 1 | Receive divider output |
| standby_n | input | 1 | 0 holds the transmit detector in standby |
| tx_drv_en | output | 1 | Transmit output driving (0 = high impedance) |
| tx_drv_hi | output | 1 | Transmit drive level (1 up, 0 down) |
| rx_drv_en | output | 1 | Receive output driving (0 = high impedance) |
| rx_drv_hi | output | 1 | Receive drive level (1 up, 0 down) |
| tx_err_width | output | CW | Length of the last transmit error pulse, in cycles |
| tx_err_lead | output | 1 | 1 if the last transmit error pulse drove high |
| rx_err_width | output | CW | Length of the last receive error pulse, in cycles |
| rx_err_lead | output | 1 | 1 if the last receive error pulse drove high |

## Verification
The bench builds the block with CW=4. This puts the width ceiling at 15 cycles, so a single 20-cycle reference lead reaches saturation within a short run. The other cases use pulses of one to six cycles, which exercise the exact width counting and both polarities on both detectors. Because the reference is shared, every reference edge is also checked against the detector that is not the focus of a given case.

// File: rtl/dual_pfd.sv
module dual_pfd #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_in,
  input  logic          tx_div_in,
  input  logic          rx_div_in,
  input  logic          standby_n,
  output logic          tx_drv_en,
  output logic          tx_drv_hi,
  output logic          rx_drv_en,
  output logic          rx_drv_hi,
  output logic [CW-1:0] tx_err_width,
  output logic          tx_err_lead,
  output logic [CW-1:0] rx_err_width,
  output logic          rx_err_lead
);
  localparam logic [CW-1:0] WMAX = {CW{1'b1}};
  localparam int LANES = 2;

  logic             ref_q;
  logic             ref_rise;
  logic [LANES-1:0] div_in;
  logic [LANES-1:0] lane_on;

  assign div_in   = {rx_div_in, tx_div_in};
  assign lane_on  = {1'b1, standby_n};
  assign ref_rise = ref_in & ~ref_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ref_q <= 1'b0;
    else        ref_q <= ref_in;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic          div_q, up, dn, lead_run, lead_out;
    logic [CW-1:0] cnt, width;
    logic          div_rise, up_nx, dn_nx, both, active;

    assign div_rise = div_in[g] & ~div_q;
    assign up_nx    = up | ref_rise;
    assign dn_nx    = dn | div_rise;
    assign both     = up_nx & dn_nx;
    assign active   = up | dn;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        div_q    <= 1'b0;
        up       <= 1'b0;
        dn       <= 1'b0;
        cnt      <= '0;
        width    <= '0;
        lead_run <= 1'b0;
        lead_out <= 1'b0;
      end else begin
        div_q <= div_in[g];
        if (!lane_on[g]) begin
          up       <= 1'b0;
          dn       <= 1'b0;
          cnt      <= '0;
          width    <= '0;
          lead_run <= 1'b0;
          lead_out <= 1'b0;
        end else begin
          up <= up_nx & ~both;
          dn <= dn_nx & ~both;
          if (active) begin
            cnt      <= (cnt == WMAX) ? WMAX : cnt + 1'b1;
            lead_run <= up;
          end else begin
            cnt <= '0;
            if (cnt != '0) begin
              width    <= cnt;
              lead_out <= lead_run;
            end
          end
        end
      end
    end
  end

  assign tx_drv_en    = g_lane[0].active;
  assign tx_drv_hi    = g_lane[0].up;
  assign rx_drv_en    = g_lane[1].active;
  assign rx_drv_hi    = g_lane[1].up;
  assign tx_err_width = g_lane[0].width;
  assign tx_err_lead  = g_lane[0].lead_out;
  assign rx_err_width = g_lane[1].width;
  assign rx_err_lead  = g_lane[1].lead_out;
endmodule

// File: rtl/dual_pfd_chk.sv
module dual_pfd_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ref_in,
  input logic          tx_div_in,
  input logic          rx_div_in,
  input logic          standby_n,
  input logic          tx_drv_en,
  input logic          tx_drv_hi,
  input logic          rx_drv_en,
  input logic          rx_drv_hi,
  input logic [CW-1:0] tx_err_width,
  input logic          tx_err_lead,
  input logic [CW-1:0] rx_err_width,
  input logic          rx_err_lead
);
  always @(negedge clk)
    if (!rst_n)
      a_r1_float_in_reset: assert (!tx_drv_en && !rx_drv_en && tx_err_width == '0
                                   && rx_err_width == '0 && !tx_err_lead && !rx_err_lead);

  a_r2_rx_ref_drives_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_in && !$past(ref_in) && !(rx_div_in && !$past(rx_div_in)) && !rx_drv_en)
      |=> (rx_drv_en && rx_drv_hi));

  a_r3_rx_div_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_div_in && !$past(rx_div_in) && !(ref_in && !$past(ref_in)) && !rx_drv_en)
      |=> (rx_drv_en && !rx_drv_hi));

  a_r4_rx_up_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_drv_en && rx_drv_hi && rx_div_in && !$past(rx_div_in)) |=> !rx_drv_en);

  a_r5_rx_coincident_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_drv_en && ref_in && !$past(ref_in) && rx_div_in && !$past(rx_div_in))
      |=> (!rx_drv_en && $stable(rx_err_width)));

  a_r7_tx_standby_float: assert property (@(posedge clk) disable iff (!rst_n)
    !standby_n |=> (!tx_drv_en && tx_err_width == '0));

  a_r7_rx_runs_in_standby: assert property (@(posedge clk) disable iff (!rst_n)
    (!standby_n && rx_drv_en && rx_drv_hi && !(rx_div_in && !$past(rx_div_in)))
      |=> (rx_drv_en && rx_drv_hi));

  a_r9_width_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (standby_n && $fell(tx_drv_en)) |=> (tx_err_width != '0));
endmodule

bind dual_pfd dual_pfd_chk #(.CW(CW)) i_dual_pfd_chk (.*);

// File: tb/test_dual_pfd.sv
module test_dual_pfd;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 4;
  localparam int EN = 0, HI = 1, WID = 2, LEAD = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0, tx_div_in = 1'b0, rx_div_in = 1'b0, standby_n = 1'b1;
  logic tx_drv_en, tx_drv_hi, rx_drv_en, rx_drv_hi, tx_err_lead, rx_err_lead;
  logic [CW-1:0] tx_err_width, rx_err_width;

  dual_pfd #(.CW(CW)) i_dual_pfd (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int    cyc;
    int    ch;
    int    kind;
    int    val;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int read_out(int ch, int kind);
    case (kind)
      EN:   return ch == 0 ? int'(tx_drv_en) : int'(rx_drv_en);
      HI:   return ch == 0 ? int'(tx_drv_hi) : int'(rx_drv_hi);
      WID:  return ch == 0 ? int'(tx_err_width) : int'(rx_err_width);
      default: return ch == 0 ? int'(tx_err_lead) : int'(rx_err_lead);
    endcase
  endfunction

  task automatic ex(int d, int ch, int kind, int val, string tag);
    exp_t e;
    int i;
    e.cyc = cyc + d; e.ch = ch; e.kind = kind; e.val = val; e.tag = tag;
    i = q.size();
    while (i > 0 && q[i-1].cyc > e.cyc) i--;
    q.insert(i, e);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic lower_all();
    ref_in = 0; tx_div_in = 0; rx_div_in = 0;
    step(2);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      int got;
      e = q.pop_front();
      got = read_out(e.ch, e.kind);
      checks++;
      if (e.cyc != cyc || got != e.val) begin
        errors++;
        $display("FAIL %s ch=%0d kind=%0d cyc=%0d: actual %0d expected %0d",
                 e.tag, e.ch, e.kind, cyc, got, e.val);
      end
    end
  end

  initial begin
    step(3);
    rst_n = 1;
    for (int ch = 0; ch < 2; ch++) begin
      ex(1, ch, EN, 0, "R1"); ex(1, ch, WID, 0, "R1"); ex(1, ch, LEAD, 0, "R1");
    end
    step(2);

    ref_in = 1;
    ex(1, 0, EN, 1, "R2"); ex(1, 0, HI, 1, "R2");
    ex(1, 1, EN, 1, "R2"); ex(1, 1, HI, 1, "R2");
    step(3);
    tx_div_in = 1; rx_div_in = 1;
    for (int ch = 0; ch < 2; ch++) begin
      ex(1, ch, EN, 0, "R4"); ex(2, ch, WID, 3, "R9"); ex(2, ch, LEAD, 1, "R9");
    end
    step(3); lower_all();

    tx_div_in = 1; rx_div_in = 1;
    for (int ch = 0; ch < 2; ch++) begin
      ex(1, ch, EN, 1, "R3"); ex(1, ch, HI, 0, "R3");
    end
    step(1);
    ref_in = 1;
    for (int ch = 0; ch < 2; ch++) begin
      ex(1, ch, EN, 0, "R4"); ex(2, ch, WID, 1, "R9"); ex(2, ch, LEAD, 0, "R9");
    end
    step(3); lower_all();

    ref_in = 1; tx_div_in = 1;
    ex(1, 0, EN, 0, "R5"); ex(2, 0, EN, 0, "R5");
    ex(1, 1, EN, 1, "R5"); ex(1, 1, HI, 1, "R5");
    step(1);
    rx_div_in = 1;
    ex(1, 1, EN, 0, "R4");
    ex(2, 1, WID, 1, "R5"); ex(2, 1, LEAD, 1, "R5");
    ex(2, 0, WID, 1, "R5"); ex(2, 0, LEAD, 0, "R5");
    step(3); lower_all();

    ref_in = 1;
    step(1); ref_in = 0;
    step(1); ref_in = 1;
    ex(1, 0, EN, 1, "R6"); ex(1, 0, HI, 1, "R6");
    step(1);
    tx_div_in = 1; rx_div_in = 1;
    ex(1, 0, EN, 0, "R6"); ex(2, 0, WID, 3, "R6"); ex(2, 1, WID, 3, "R6");
    step(3); lower_all();

    ref_in = 1;
    step(2);
    standby_n = 0;
    ex(1, 0, EN, 0, "R7"); ex(1, 0, WID, 0, "R7"); ex(1, 0, LEAD, 0, "R7");
    ex(1, 1, EN, 1, "R7"); ex(1, 1, HI, 1, "R7");
    step(1);
    tx_div_in = 1;
    ex(1, 0, EN, 0, "R7"); ex(2, 0, EN, 0, "R7"); ex(2, 1, EN, 1, "R7");
    step(2);
    standby_n = 1;
    ex(1, 0, EN, 0, "R8"); ex(2, 0, EN, 0, "R8");
    step(1);
    rx_div_in = 1;
    ex(1, 1, EN, 0, "R4"); ex(2, 1, WID, 6, "R7"); ex(2, 1, LEAD, 1, "R7");
    step(3); lower_all();

    tx_div_in = 1; rx_div_in = 1;
    ex(1, 0, EN, 1, "R8"); ex(1, 0, HI, 0, "R8");
    step(1);
    ref_in = 1;
    ex(1, 0, EN, 0, "R8"); ex(2, 0, WID, 1, "R8");
    step(3); lower_all();

    ref_in = 1;
    step(20);
    tx_div_in = 1; rx_div_in = 1;
    for (int ch = 0; ch < 2; ch++) begin
      ex(1, ch, EN, 0, "R10"); ex(2, ch, WID, 15, "R10"); ex(2, ch, LEAD, 1, "R10");
    end
    step(4);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule